// File: doc/BRIEF.md
# Per-Port Memory Deadman Timer Bank

This block holds one watchdog counter for each memory port. A supervisor has to prove, port by port, that it is still watching that port's power and thermal state. It does so by reading the port's status register often enough. Each counter advances on a one-millisecond tick. If a port goes longer than its programmed timeout without a read, the block sets a sticky expired flag for that port. That flag drives the port's emergency throttle request to the memory controller.

Each port's timeout is written in units of 100 ticks through a simple strobe interface, which gives a range of 100 ms to 28 s. A read of a port returns that port's elapsed count and its expired flag as they stood before the read. The same read then restarts the count and clears the flag. A timeout write also restarts the count, but it leaves an expiry already in place. The ports never share state. A write or read aimed at one port leaves every other port untouched.

Top module: `mem_deadman_bank`

## Requirements
- R1: After reset, every throttle output is 0, every elapsed count is 0, and every port's timeout is 280 units (28000 ticks).
- R2: Each port has its own counter, timeout and flag. A timeout write or a read strobe changes only the port selected by its port index, and one port's expiry never changes another port's throttle output.
- R3: The timeout is a 9-bit value in units of 100 ticks, so the values 1 to 280 cover 100 ms to 28 s.
- R4: While a port is not expired, each tick adds one to its elapsed count. The tick that brings the count up to the timeout sets the expired flag, and that port's throttle output is 1 from the clock edge of that tick onward.
- R5: Once a port has expired, its elapsed count holds and its throttle output stays 1 through any number of ticks until that port is read.
- R6: A read strobe produces rd_valid one cycle later, with rd_data bits [14:0] holding the elapsed count, bit 31 holding the expired flag and all other bits 0. The values are those held before the read. The read clears that port's elapsed count and expired flag.
- R7: A timeout write loads the new value and sets the port's elapsed count to 0, but it does not clear an expired flag that is already set.
- R8: A programmed timeout of 0 behaves as a timeout of 1 unit (100 ticks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_we | input | 1 | Timeout write strobe |
| cfg_port | input | PORT_W | Port selected by the write |
| cfg_units | input | 9 | New timeout in 100-tick units |
| rd_en | input | 1 | Status read strobe (this is the kick) |
| rd_port | input | PORT_W | Port selected by the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Expired flag in bit 31, elapsed count in [14:0] |
| throttle | output | NUM_PORTS | Emergency throttle request, one bit per port |

## Verification
The assertions check these rules on every cycle:
- the elapsed count never passes the port's limit;
- an expired flag holds until a read;
- a read clears both the count and the flag;
- a write clears the count but keeps the flag;
- an unexpired tick adds exactly one;
- every read gets a response on the next cycle.

Some behaviour can only be shown by the bench's scenarios:
- expiry lands on exactly the right tick, at the shortest timeout, at a timeout of 0 and at the 28 s maximum;
- read data shows the values from before the read;
- ports stay independent while several of them count and expire side by side.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  localparam int UNIT_W    = 9;
  localparam int ELAPSED_W = 15;
  localparam int RD_W      = 32;
  localparam int MAX_UNITS = 280;

  typedef struct packed {
    logic                 expired;
    logic [15:0]          rsvd;
    logic [ELAPSED_W-1:0] elapsed;
  } rd_word_t;
endpackage

// File: rtl/mdt_port_timer.sv
module mdt_port_timer
  import mdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 100,
  parameter int RESET_UNITS    = MAX_UNITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 cfg_hit,
  input  logic [UNIT_W-1:0]    cfg_units,
  input  logic                 rd_hit,
  output logic [ELAPSED_W-1:0] elapsed_o,
  output logic                 expired_o
);
  logic [UNIT_W-1:0]    units_q;
  logic [UNIT_W-1:0]    units_eff;
  logic [31:0]          lim_wide;
  logic [ELAPSED_W-1:0] limit_ticks;
  logic [ELAPSED_W-1:0] elapsed_q;
  logic [ELAPSED_W-1:0] next_cnt;
  logic                 expired_q;

  always_comb begin
    units_eff   = (units_q == '0) ? UNIT_W'(1) : units_q;
    lim_wide    = 32'(units_eff) * 32'(TICKS_PER_UNIT);
    limit_ticks = lim_wide[ELAPSED_W-1:0];
    next_cnt    = elapsed_q + ELAPSED_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      units_q   <= UNIT_W'(RESET_UNITS);
      elapsed_q <= '0;
      expired_q <= 1'b0;
    end else begin
      if (cfg_hit) units_q <= cfg_units;
      if (rd_hit) begin
        elapsed_q <= '0;
        expired_q <= 1'b0;
      end else if (cfg_hit) begin
        elapsed_q <= '0;
      end else if (tick && !expired_q) begin
        elapsed_q <= next_cnt;
        if (next_cnt >= limit_ticks) expired_q <= 1'b1;
      end
    end
  end

  assign elapsed_o = elapsed_q;
  assign expired_o = expired_q;

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    elapsed_q <= limit_ticks);

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !expired_q && !rd_hit && !cfg_hit |=> elapsed_q == $past(elapsed_q) + ELAPSED_W'(1));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    expired_q && !rd_hit |=> expired_q);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> !expired_q && elapsed_q == '0);

  // R7
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_hit && !rd_hit |=> elapsed_q == '0 && expired_q == $past(expired_q));
endmodule

// File: rtl/mdt_read_mux.sv
module mdt_read_mux
  import mdt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 rd_en,
  input  logic [PORT_W-1:0]                    rd_port,
  input  logic [NUM_PORTS-1:0][ELAPSED_W-1:0]  elapsed_all,
  input  logic [NUM_PORTS-1:0]                 expired_all,
  output logic                                 rd_valid,
  output logic [RD_W-1:0]                      rd_data
);
  rd_word_t word_d;

  always_comb begin
    word_d = '0;
    if (32'(rd_port) < NUM_PORTS) begin
      word_d.expired = expired_all[rd_port];
      word_d.elapsed = elapsed_all[rd_port];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_d;
    end
  end

  // R6
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/mem_deadman_bank.sv
module mem_deadman_bank
  import mdt_pkg::*;
#(
  parameter int NUM_PORTS      = 4,
  parameter int TICKS_PER_UNIT = 100,
  parameter int RESET_UNITS    = MAX_UNITS,
  localparam int PORT_W        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ms_tick,
  input  logic                 cfg_we,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [UNIT_W-1:0]    cfg_units,
  input  logic                 rd_en,
  input  logic [PORT_W-1:0]    rd_port,
  output logic                 rd_valid,
  output logic [RD_W-1:0]      rd_data,
  output logic [NUM_PORTS-1:0] throttle
);
  logic [NUM_PORTS-1:0][ELAPSED_W-1:0] elapsed_all;
  logic [NUM_PORTS-1:0]                expired_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic cfg_sel;
    logic rd_sel;
    assign cfg_sel = cfg_we && (cfg_port == PORT_W'(p));
    assign rd_sel  = rd_en  && (rd_port  == PORT_W'(p));

    mdt_port_timer #(
      .TICKS_PER_UNIT(TICKS_PER_UNIT),
      .RESET_UNITS   (RESET_UNITS)
    ) i_timer (
      .clk      (clk),
      .rst      (rst),
      .tick     (ms_tick),
      .cfg_hit  (cfg_sel),
      .cfg_units(cfg_units),
      .rd_hit   (rd_sel),
      .elapsed_o(elapsed_all[p]),
      .expired_o(expired_all[p])
    );
  end

  mdt_read_mux #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W)
  ) i_rdmux (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_port    (rd_port),
    .elapsed_all(elapsed_all),
    .expired_all(expired_all),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign throttle = expired_all;

  // R2
  throttle_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(throttle & ~$past(throttle)) <= 1 || ms_tick || $past(ms_tick));
endmodule

// File: tb/test_mem_deadman_bank.sv
module test_mem_deadman_bank;
  localparam int NP = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ms_tick = 1'b0;
  logic          cfg_we = 1'b0;
  logic [PW-1:0] cfg_port = '0;
  logic [8:0]    cfg_units = '0;
  logic          rd_en = 1'b0;
  logic [PW-1:0] rd_port = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] throttle;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mem_deadman_bank #(.NUM_PORTS(NP)) i_mem_deadman_bank (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_units(cfg_units),
    .rd_en(rd_en), .rd_port(rd_port),
    .rd_valid(rd_valid), .rd_data(rd_data), .throttle(throttle)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pop expected read words as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected read data: actual %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s read data: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic ticks(int n);
    ms_tick = 1'b1;
    repeat (n) @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic wr(int p, int u);
    cfg_we = 1'b1; cfg_port = PW'(p); cfg_units = 9'(u);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int p, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; rd_port = PW'(p);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_thr(logic [NP-1:0] e, string t);
    n_checks++;
    if (throttle !== e) begin
      n_fail++;
      $display("FAIL %s throttle: actual %b expected %b", t, throttle, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_thr(4'b0000, "R1");
    rd(0, 32'h0, "R1");
    // ports 0 and 2: one and two units
    wr(0, 1);
    wr(2, 2);
    ticks(50);
    rd(0, 32'd50, "R6");               // R6 elapsed before read
    ticks(99);
    chk_thr(4'b0000, "R4");            // R3 100-tick unit not yet reached
    ticks(1);
    chk_thr(4'b0001, "R4");            // R4 expiry on the limit tick
    ticks(10);
    chk_thr(4'b0001, "R5");            // R5 sticky through ticks
    rd(0, 32'h8000_0064, "R5");        // R5 count held at 100, flag set
    chk_thr(4'b0000, "R6");            // R6 read clears flag
    rd(0, 32'h0, "R6");                // R6 read cleared count
    // R8 zero timeout acts as one unit; R2 independence
    wr(1, 0);
    ticks(39);
    chk_thr(4'b0000, "R2");
    ticks(1);
    chk_thr(4'b0100, "R2");            // port 2 reached 200 alone
    ticks(59);
    chk_thr(4'b0100, "R8");
    ticks(1);
    chk_thr(4'b0111, "R8");            // ports 0 and 1 at 100
    // R7 write restarts count, keeps flag
    wr(1, 3);
    chk_thr(4'b0111, "R7");
    rd(1, 32'h8000_0000, "R7");
    chk_thr(4'b0101, "R2");            // R2 only port 1 cleared
    ticks(5);
    wr(3, 280);
    rd(3, 32'h0, "R7");                // R7 write restarted port 3
    // R3 maximum timeout 28000 ticks
    ticks(27999);
    n_checks++;
    if (throttle[3] !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 throttle[3] early: actual %b expected 0", throttle[3]);
    end
    ticks(1);
    n_checks++;
    if (throttle[3] !== 1'b1) begin
      n_fail++;
      $display("FAIL R3 throttle[3] at max: actual %b expected 1", throttle[3]);
    end
    rd(3, 32'h8000_6D60, "R3");
    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule